// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Unit

This unit turns the synchronized input levels of one I/O bank into a single bank interrupt. A 3-bit event-select code for each line chooses what the line watches: a falling edge, a rising edge, either edge, a low level or a high level. Each detected event sets a status bit for its line. A mask, built up and torn down through write-one set and clear registers, decides which pending status bits may raise the bank interrupt. Masked lines still record their events.

Software services the interrupt by reading the status register. The read returns every pending event and clears them in the same access, so no separate acknowledge step is needed. An event that arrives in the very cycle of that read is not lost: it stays pending after the clear. Edge detection compares each line with its level one cycle earlier. Under reset that earlier level is loaded from the live inputs, so a line that is already high or low when reset ends does not produce a false edge.

The register port is a simple single-cycle strobe interface with byte offsets inside the bank. Read data is registered and appears on the cycle after the read strobe.

Top module: `gpio_irq_event_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, mask and status read as zero and `irq` is low; no edge is reported for a line whose level was already steady during reset, even with a both-edge code selected.
- R2: A write to offset 0x20 sets every mask bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R3: A write to offset 0x24 clears every mask bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: Code 0 records an event on a high-to-low change of the line and code 1 on a low-to-high change; the opposite edge records nothing.
- R5: Code 2 records an event on both a rising and a falling change of the line.
- R6: Code 3 records an event on every cycle the line is low and code 4 on every cycle it is high, so the bit comes back after a clearing read while the level holds.
- R7: Codes 5, 6 and 7 never record an event, whatever the line does.
- R8: Events on lines whose mask bit is 0 are still recorded in status; the mask gates only `irq`.
- R9: `irq` is high exactly when some status bit and its mask bit are both 1, one cycle after the event or mask change that causes it.
- R10: A read of offset 0x2C returns the status on `rdata` on the next cycle and clears all bits that were pending; a read of 0x28 returns the mask and leaves it unchanged.
- R11: An event detected in the same cycle as a status read is set after the clear and is returned by the next status read.
- R12: The mask at 0x28 is read-only: a write there, or to any offset other than 0x20 and 0x24, leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_level | input | LINES | Synchronized line levels |
| line_code | input | 3*LINES | Event-select code, line i in bits [3i+2:3i] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset in the bank |
| wdata | input | LINES | Write data |
| rdata | output | LINES | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Bank interrupt |

## Verification
The bench aims at the read that coincides with a new edge: a design that clears status unconditionally would drop that event, and the follow-up read would come back empty. It holds lines high through reset with a both-edge code, which a design that resets the previous-level register to zero would answer with a false rising event. It reads a level-coded line twice while the level holds, catching a design that treats level codes as edges, and drives lines under codes 5 to 7, catching a decoder that falls through to an edge or level case. It also writes zeros and writes to the mask offset, which a design that loads rather than ORs or that decodes the read-only offset would turn into lost or spurious mask bits.

// File: rtl/gpio_evt_pkg.sv
// Package: shared types and register offsets for the GPIO bank interrupt
// event unit. Assumes byte offsets inside one bank.
package gpio_evt_pkg;

    // Event-select codes; values above EVT_HIGH select nothing.
    typedef enum logic [2:0] {
        EVT_FALL = 3'd0,
        EVT_RISE = 3'd1,
        EVT_BOTH = 3'd2,
        EVT_LOW  = 3'd3,
        EVT_HIGH = 3'd4
    } evt_code_e;

    localparam int CODE_W = 3;

    // Register byte offsets inside the bank.
    localparam int OFS_IRQ_SET    = 'h20;
    localparam int OFS_IRQ_CLR    = 'h24;
    localparam int OFS_IRQ_MASK   = 'h28;
    localparam int OFS_IRQ_STATUS = 'h2C;

endpackage

// File: rtl/gpio_evt_line_detect.sv
// Module: per-line event detector. Keeps the line's level from the previous
// cycle and decodes the event-select code into a one-cycle event pulse.
// Assumes line_level is already synchronized to clk. Under reset the
// previous level follows the live input so no edge is seen at reset exit.
module gpio_evt_line_detect
    import gpio_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [CODE_W-1:0] code,
    output logic              evt
);

    logic      prev_q;
    evt_code_e sel;

    assign sel = evt_code_e'(code);

    // Track the line level of the previous cycle; preload it during reset.
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    // Decode the selected condition against current and previous level.
    always_comb begin
        case (sel)
            EVT_FALL: evt = prev_q & ~lvl;
            EVT_RISE: evt = ~prev_q & lvl;
            EVT_BOTH: evt = prev_q ^ lvl;
            EVT_LOW:  evt = ~lvl;
            EVT_HIGH: evt = lvl;
            default:  evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_evt_mask_reg.sv
// Module: interrupt mask register with write-one-to-set and
// write-one-to-clear access. Assumes set and clear strobes are never
// active in the same cycle (they decode different offsets).
module gpio_evt_mask_reg #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [LINES-1:0] bits,
    output logic [LINES-1:0] mask
);

    logic [LINES-1:0] set_v;
    logic [LINES-1:0] clr_v;

    // Qualify the write data by the strobe that carries it.
    always_comb begin
        set_v = set_en ? bits : '0;
        clr_v = clr_en ? bits : '0;
    end

    // Hold the mask; ones in the write data set or clear single bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            mask <= (mask | set_v) & ~clr_v;
        end
    end

endmodule

// File: rtl/gpio_evt_status_reg.sv
// Module: pending-event status register that clears on read. Events seen
// in the clearing cycle are kept, so a read never swallows a new event.
module gpio_evt_status_reg #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LINES-1:0] evt,
    output logic [LINES-1:0] status
);

    logic [LINES-1:0] keep;

    // Pending bits survive unless this cycle is a clearing read.
    always_comb begin
        keep = clr ? '0 : status;
    end

    // Accumulate new events on top of the kept bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= keep | evt;
        end
    end

endmodule

// File: rtl/gpio_irq_event_unit.sv
// Module: GPIO bank interrupt event unit (top). One detector per line feeds
// a clear-on-read status register; a write-one set/clear mask gates the
// single bank interrupt. Register reads are registered: rdata is valid on
// the cycle after rd_en. Assumes wr_en and rd_en are not both high.
module gpio_irq_event_unit
    import gpio_evt_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINES-1:0]        line_level,
    input  logic [CODE_W*LINES-1:0] line_code,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LINES-1:0]        wdata,
    output logic [LINES-1:0]        rdata,
    output logic                    irq
);

    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_IRQ_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_IRQ_CLR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_IRQ_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_IRQ_STATUS);

    logic [LINES-1:0] line_evt;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] status_q;
    logic             hit_set;
    logic             hit_clr;
    logic             hit_mask;
    logic             hit_stat;
    logic [LINES-1:0] rd_mux;

    // One edge/level detector per line.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_evt_line_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (line_level[i]),
            .code  (line_code[CODE_W*i +: CODE_W]),
            .evt   (line_evt[i])
        );
    end

    // Decode the register strobes from the byte offset.
    always_comb begin
        hit_set  = wr_en && (addr == A_SET);
        hit_clr  = wr_en && (addr == A_CLR);
        hit_mask = rd_en && (addr == A_MASK);
        hit_stat = rd_en && (addr == A_STAT);
    end

    gpio_evt_mask_reg #(.LINES(LINES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (hit_set),
        .clr_en (hit_clr),
        .bits   (wdata),
        .mask   (mask_q)
    );

    gpio_evt_status_reg #(.LINES(LINES)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hit_stat),
        .evt    (line_evt),
        .status (status_q)
    );

    // Select read data: status, mask, or zero for write-only offsets.
    always_comb begin
        if (hit_stat) begin
            rd_mux = status_q;
        end else if (hit_mask) begin
            rd_mux = mask_q;
        end else begin
            rd_mux = '0;
        end
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    // Bank interrupt: any pending and enabled line.
    always_comb begin
        irq = |(status_q & mask_q);
    end

endmodule

// File: rtl/gpio_irq_event_chk.sv
// Module: assertion checker for the GPIO bank interrupt event unit, bound
// into every instance of the top module.
module gpio_irq_event_chk
    import gpio_evt_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [LINES-1:0]        wdata,
    input logic [CODE_W*LINES-1:0] line_code,
    input logic [LINES-1:0]        line_evt,
    input logic [LINES-1:0]        mask_q,
    input logic [LINES-1:0]        status_q,
    input logic                    irq
);

    logic [LINES-1:0] dead_code;

    // Lines whose code selects no event.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            dead_code[i] = line_code[CODE_W*i +: CODE_W] > 3'd4;
        end
    end

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_IRQ_SET)) |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_IRQ_CLR)) |=> ((mask_q & $past(wdata)) == '0));

    // R12
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADDR_W'(OFS_IRQ_SET) || addr == ADDR_W'(OFS_IRQ_CLR))) |=> $stable(mask_q));

    // R7
    dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt & dead_code) == '0);

    // R8
    evt_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt != '0) |=> ((status_q & $past(line_evt)) == $past(line_evt)));

    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_IRQ_STATUS)) |=> ((status_q & ~$past(line_evt)) == '0));

    // R9
    no_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

bind gpio_irq_event_unit gpio_irq_event_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .line_code (line_code),
    .line_evt  (line_evt),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .irq       (irq)
);

// File: tb/tb_gpio_irq_event_unit.sv
module tb_gpio_irq_event_unit;

    localparam int LINES  = 32;
    localparam int ADDR_W = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LINES-1:0]     line_level = '0;
    logic [3*LINES-1:0]   line_code;
    logic [2:0]           codes [LINES];
    logic                 wr_en = 1'b0;
    logic                 rd_en = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [LINES-1:0]     wdata = '0;
    logic [LINES-1:0]     rdata;
    logic                 irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [LINES-1:0] exp_q [$];
    string            tag_q [$];
    logic             rd_seen = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < LINES; i++) line_code[3*i +: 3] = codes[i];
    end

    gpio_irq_event_unit #(.LINES(LINES), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .line_level(line_level), .line_code(line_code),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [LINES-1:0] act, logic [LINES-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: issue a read and push the expected read data.
    task automatic do_read(logic [ADDR_W-1:0] a, logic [LINES-1:0] exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        rd_en = 1'b1;
        addr  = a;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic do_write(logic [ADDR_W-1:0] a, logic [LINES-1:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    // Monitor: a read sampled at a rising edge has data by the next falling edge.
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [LINES-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: lines steady high/low under reset with both-edge code.
        for (int i = 0; i < LINES; i++) codes[i] = 3'd2;
        line_level = 32'hFFFF_0000;
        repeat (3) tick();
        check("R1 irq in reset", {31'd0, irq}, '0);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'd0, irq}, '0);
        do_read(8'h2C, 32'h0, "R1 status after reset");
        do_read(8'h28, 32'h0, "R1 mask after reset");
        for (int i = 0; i < LINES; i++) codes[i] = 3'd7;
        line_level = '0;
        tick();
        do_read(8'h2C, 32'h0, "R7 flush with dead codes");

        // R2 / R3 / R12: mask access.
        do_write(8'h20, 32'h0000_00F0);
        do_read(8'h28, 32'h0000_00F0, "R2 set bits");
        do_write(8'h20, 32'h0000_000F);
        do_read(8'h28, 32'h0000_00FF, "R2 zeros keep bits");
        do_write(8'h24, 32'h0000_0030);
        do_read(8'h28, 32'h0000_00CF, "R3 clear bits");
        do_write(8'h28, 32'hFFFF_FFFF);
        do_read(8'h28, 32'h0000_00CF, "R12 mask offset read-only");
        do_write(8'h2C, 32'hFFFF_FFFF);
        do_read(8'h28, 32'h0000_00CF, "R12 other offset");
        do_read(8'h28, 32'h0000_00CF, "R10 mask read keeps mask");

        // R4: rising on line 0, falling on line 1.
        codes[0] = 3'd1;
        codes[1] = 3'd0;
        line_level[1:0] = 2'b11;
        tick();
        check("R9 irq after rising event", {31'd0, irq}, 32'd1);
        do_read(8'h2C, 32'h1, "R4 rising only");
        check("R9 irq low after clear", {31'd0, irq}, '0);
        line_level[1:0] = 2'b00;
        tick();
        do_read(8'h2C, 32'h2, "R4 falling only");
        do_read(8'h2C, 32'h0, "R10 second read empty");
        codes[0] = 3'd7;
        codes[1] = 3'd7;

        // R5: both edges on line 2.
        codes[2] = 3'd2;
        line_level[2] = 1'b1;
        tick();
        do_read(8'h2C, 32'h4, "R5 rise");
        line_level[2] = 1'b0;
        tick();
        do_read(8'h2C, 32'h4, "R5 fall");
        codes[2] = 3'd7;
        tick();

        // R6: levels on line 3.
        codes[3] = 3'd4;
        line_level[3] = 1'b1;
        tick();
        do_read(8'h2C, 32'h8, "R6 high level");
        do_read(8'h2C, 32'h8, "R6 high level again");
        codes[3] = 3'd3;
        line_level[3] = 1'b0;
        do_read(8'h2C, 32'h8, "R6 flush");
        do_read(8'h2C, 32'h8, "R6 low level");
        codes[3] = 3'd7;
        do_read(8'h2C, 32'h8, "R6 flush last");
        do_read(8'h2C, 32'h0, "R6 level gone");

        // R7: codes 5..7 ignore edges and levels.
        codes[4] = 3'd5; codes[5] = 3'd6; codes[6] = 3'd7;
        line_level[6:4] = 3'b111;
        tick();
        tick();
        line_level[6:4] = 3'b000;
        tick();
        tick();
        do_read(8'h2C, 32'h0, "R7 dead codes");
        check("R7 irq", {31'd0, irq}, '0);

        // R8: masked line 8 still recorded, irq stays low.
        codes[8] = 3'd1;
        line_level[8] = 1'b1;
        tick();
        check("R8 irq masked", {31'd0, irq}, '0);
        do_read(8'h2C, 32'h100, "R8 masked recorded");
        codes[8] = 3'd7;

        // R9: disabling the line drops irq, status stays pending.
        codes[0] = 3'd1;
        line_level[0] = 1'b1;
        tick();
        check("R9 irq set", {31'd0, irq}, 32'd1);
        do_write(8'h24, 32'h1);
        check("R9 irq after disable", {31'd0, irq}, '0);
        do_write(8'h20, 32'h1);
        check("R9 irq after re-enable", {31'd0, irq}, 32'd1);
        do_read(8'h2C, 32'h1, "R8 status kept through disable");
        codes[0] = 3'd7;

        // R11: event during the clearing read survives.
        codes[9]  = 3'd1;
        codes[10] = 3'd1;
        line_level[10] = 1'b1;
        tick();
        line_level[9] = 1'b1;
        do_read(8'h2C, 32'h400, "R11 read before new event");
        do_read(8'h2C, 32'h200, "R11 event kept");
        do_read(8'h2C, 32'h0, "R11 then clear");

        tick();
        tick();
        check("queue drained", exp_q.size(), 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule